// File: doc/BRIEF.md
# Device Address Filter with Configuration Store

This block sits behind three serial target ports (two bank ports and one control port) and judges each received device-address byte. For every byte it reports whether the port should acknowledge, whether the requested read or write may go on, whether the target is the configuration area or memory, and, on the control port, which memory bank is addressed. The judgement draws on a 16-byte configuration store that the block itself holds. The store supplies a programmable target address for each port, a per-port switch that turns address comparison on or off, and a per-port access level.

The serial bit engine presents a byte with `addr_vld` and the port number. The verdict is registered and appears one clock later. The same engine reaches the configuration store through a simple indexed write port and a combinational read port whenever the control port has selected the configuration area. Each received byte carries the 7-bit device address in bits 7:1 and the direction in bit 0, where 1 means read.

Top module: `afp_filter`

## Requirements
- R1: After reset, every port's address field reads 0 with its compare switch set to 1, every access level reads 11, byte 15 holds the revision parameter, and all other bytes read 0.
- R2: A verdict appears with `dec_vld` high exactly one clock after `addr_vld`. In every other cycle `dec_vld`, `dec_ack`, `dec_go`, `dec_cfg` and `dec_bank` are all 0.
- R3: A memory access is only recognised when byte bits 7:4 equal 1010. Any other code, apart from the case in R7, gives no acknowledge and no go.
- R4: Port 0 uses configuration byte 0 and port 1 uses byte 1. Bits 2:0 of that byte are compared with byte bits 3:1 of the received byte.
- R5: Port 2 (control) compares bits 1:0 of configuration byte 2 with received bits 3:2. Received bit 1 is reported on `dec_bank` whenever that port acknowledges a memory access.
- R6: When bit 4 of a port's address byte is 0, that port's address field is ignored and any value in those positions matches.
- R7: On port 2, device address 1011100 selects the configuration area (`dec_ack`, `dec_go`, `dec_cfg` all 1) whatever port 2's access level is. On ports 0 and 1 that address is not acknowledged.
- R8: Bits 1:0 of configuration bytes 8, 9 and 10 hold the access level of ports 0, 1 and 2. Level 00 gives neither acknowledge nor go for a matching memory access.
- R9: Access level 01 acknowledges a matching memory access and withholds go for both reads and writes.
- R10: Access level 10 acknowledges a matching memory access and gives go only for a read (bit 0 = 1).
- R11: Access level 11 acknowledges a matching memory access and gives go for both directions.
- R12: Bytes other than 15 store any written value and read it back. A write to byte 15 leaves its value unchanged.
- R13: Port number 3 is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Received address byte present this cycle |
| addr_port | input | 2 | Port that received the byte (0, 1 bank ports, 2 control) |
| addr_byte | input | 8 | Device address in 7:1, direction in 0 |
| cfg_wr_en | input | 1 | Write strobe for the configuration store |
| cfg_idx | input | 4 | Configuration byte index for read and write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte at `cfg_idx` |
| dec_vld | output | 1 | Verdict valid |
| dec_ack | output | 1 | Port should acknowledge |
| dec_go | output | 1 | Requested operation may proceed |
| dec_cfg | output | 1 | Target is the configuration area |
| dec_bank | output | 1 | Bank select from the control port |

## Verification
The assertions take it that `addr_vld` is a single-cycle strobe per received byte. Back-to-back bytes are allowed but each yields its own verdict. They also take it that `addr_port` and `addr_byte` are stable and known while the strobe is high. A configuration write takes effect from the next clock, so a verdict in the same cycle still uses the old setting. The bench never issues a write and a byte in the same cycle, and it drives every input on the falling edge so that all values are settled at the sampling edge.

// File: rtl/afp_pkg.sv
package afp_pkg;

    localparam int PORT_W  = 2;
    localparam int NPORT   = 3;
    localparam int CTL_IDX = 2;

    typedef enum logic [1:0] {
        LVL_SHUT    = 2'b00,
        LVL_ACKONLY = 2'b01,
        LVL_RDONLY  = 2'b10,
        LVL_OPEN    = 2'b11
    } level_e;

    typedef struct packed {
        logic vld;
        logic ack;
        logic go;
        logic cfg;
        logic bank;
    } verdict_t;

endpackage

// File: rtl/afp_cfg_store.sv
module afp_cfg_store #(
    parameter int          DATA_W    = 8,
    parameter int          DEPTH     = 16,
    parameter int          NPORT     = 3,
    parameter int          ADDR_BASE = 0,
    parameter int          LVL_BASE  = 8,
    parameter int          EN_BIT    = 4,
    parameter logic [7:0]  REV_CODE  = 8'h21,
    localparam int         IDX_W     = $clog2(DEPTH),
    localparam int         REV_IDX   = DEPTH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        port_addr [NPORT],
    output logic              port_en   [NPORT],
    output logic [1:0]        port_lvl  [NPORT]
);

    logic [DATA_W-1:0] regs_d [DEPTH];
    logic [DATA_W-1:0] regs_q [DEPTH];

    function automatic logic [DATA_W-1:0] init_val(int i);
        logic [DATA_W-1:0] v;
        v = '0;
        if (i >= ADDR_BASE && i < ADDR_BASE + NPORT) v[EN_BIT] = 1'b1;
        if (i >= LVL_BASE && i < LVL_BASE + NPORT)   v[1:0]   = 2'b11;
        if (i == REV_IDX)                            v        = DATA_W'(REV_CODE);
        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) regs_d[i] = regs_q[i];
        if (wr_en && (int'(idx) != REV_IDX)) regs_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= init_val(i);
        end else begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = regs_q[idx];

    for (genvar p = 0; p < NPORT; p++) begin : g_fields
        assign port_addr[p] = regs_q[ADDR_BASE + p][2:0];
        assign port_en[p]   = regs_q[ADDR_BASE + p][EN_BIT];
        assign port_lvl[p]  = regs_q[LVL_BASE + p][1:0];
    end

    // R12
    rev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(idx) == REV_IDX) |=> $stable(regs_q[REV_IDX]));

    // R12
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(idx) != REV_IDX) |=> (rdata == $past(wdata) || idx != $past(idx)));

endmodule

// File: rtl/afp_port_match.sv
module afp_port_match #(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter int         SEL_W    = 3,
    parameter bit         HAS_BANK = 1'b0,
    localparam int        LO       = 3 - SEL_W
) (
    input  logic [6:0] dev_addr,
    input  logic [2:0] sel_bits,
    input  logic       sel_en,
    output logic       hit,
    output logic       bank
);

    logic code_ok;
    logic sel_ok;

    assign code_ok = (dev_addr[6:3] == DEV_CODE);
    assign sel_ok  = !sel_en || (dev_addr[2:LO] == sel_bits[SEL_W-1:0]);
    assign hit     = code_ok && sel_ok;

    if (HAS_BANK) begin : g_bank
        assign bank = dev_addr[0];
    end else begin : g_nobank
        assign bank = 1'b0;
    end

endmodule

// File: rtl/afp_level_gate.sv
module afp_level_gate
    import afp_pkg::*;
(
    input  logic   mem_hit,
    input  logic   cfg_hit,
    input  logic   is_read,
    input  level_e level,
    output logic   ack,
    output logic   go
);

    always_comb begin
        ack = 1'b0;
        go  = 1'b0;
        if (cfg_hit) begin
            ack = 1'b1;
            go  = 1'b1;
        end else if (mem_hit) begin
            unique case (level)
                LVL_SHUT:    begin ack = 1'b0; go = 1'b0;    end
                LVL_ACKONLY: begin ack = 1'b1; go = 1'b0;    end
                LVL_RDONLY:  begin ack = 1'b1; go = is_read; end
                LVL_OPEN:    begin ack = 1'b1; go = 1'b1;    end
                default:     begin ack = 1'b0; go = 1'b0;    end
            endcase
        end
    end

endmodule

// File: rtl/afp_filter.sv
module afp_filter
    import afp_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter logic [6:0] CFG_DEV  = 7'b1011100,
    parameter logic [7:0] REV_CODE = 8'h21,
    parameter int         DEPTH    = 16,
    localparam int        IDX_W    = $clog2(DEPTH),
    localparam int        NSLOT    = 1 << PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld,
    input  logic [PORT_W-1:0] addr_port,
    input  logic [7:0]        addr_byte,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              dec_vld,
    output logic              dec_ack,
    output logic              dec_go,
    output logic              dec_cfg,
    output logic              dec_bank
);

    logic [2:0] port_addr [NPORT];
    logic       port_en   [NPORT];
    logic [1:0] port_lvl  [NPORT];

    logic       slot_hit  [NSLOT];
    logic       slot_bank [NSLOT];
    level_e     slot_lvl  [NSLOT];

    logic       sel_hit, sel_bank, cfg_hit, g_ack, g_go;
    level_e     sel_lvl;
    verdict_t   st_d, st_q;

    afp_cfg_store #(
        .DATA_W   (8),
        .DEPTH    (DEPTH),
        .NPORT    (NPORT),
        .ADDR_BASE(0),
        .LVL_BASE (8),
        .EN_BIT   (4),
        .REV_CODE (REV_CODE)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .port_addr(port_addr),
        .port_en  (port_en),
        .port_lvl (port_lvl)
    );

    for (genvar p = 0; p < NSLOT; p++) begin : g_slot
        if (p < NPORT) begin : g_live
            afp_port_match #(
                .DEV_CODE(DEV_CODE),
                .SEL_W   ((p == CTL_IDX) ? 2 : 3),
                .HAS_BANK((p == CTL_IDX) ? 1'b1 : 1'b0)
            ) match_i (
                .dev_addr(addr_byte[7:1]),
                .sel_bits(port_addr[p]),
                .sel_en  (port_en[p]),
                .hit     (slot_hit[p]),
                .bank    (slot_bank[p])
            );
            assign slot_lvl[p] = level_e'(port_lvl[p]);
        end else begin : g_dead
            assign slot_hit[p]  = 1'b0;
            assign slot_bank[p] = 1'b0;
            assign slot_lvl[p]  = LVL_SHUT;
        end
    end

    assign sel_hit  = slot_hit[addr_port];
    assign sel_bank = slot_bank[addr_port];
    assign sel_lvl  = slot_lvl[addr_port];
    assign cfg_hit  = (int'(addr_port) == CTL_IDX) && (addr_byte[7:1] == CFG_DEV);

    afp_level_gate gate_i (
        .mem_hit(sel_hit),
        .cfg_hit(cfg_hit),
        .is_read(addr_byte[0]),
        .level  (sel_lvl),
        .ack    (g_ack),
        .go     (g_go)
    );

    always_comb begin
        st_d      = '0;
        st_d.vld  = addr_vld;
        if (addr_vld) begin
            st_d.ack  = g_ack;
            st_d.go   = g_go;
            st_d.cfg  = cfg_hit;
            st_d.bank = g_ack && !cfg_hit && sel_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_vld  = st_q.vld;
    assign dec_ack  = st_q.ack;
    assign dec_go   = st_q.go;
    assign dec_cfg  = st_q.cfg;
    assign dec_bank = st_q.bank;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |=> dec_vld);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> (!dec_vld && !dec_ack && !dec_go && !dec_cfg && !dec_bank));

    // R9
    go_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_go |-> dec_ack);

    // R7
    cfg_ctl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && int'(addr_port) != CTL_IDX) |=> !dec_cfg);

    // R5
    bank_ctl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && int'(addr_port) != CTL_IDX) |=> !dec_bank);

    // R13
    no_ack_slot3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && addr_port == 2'd3) |=> !dec_ack);

    // R3
    code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && addr_byte[7:4] != DEV_CODE && !cfg_hit) |=> !dec_ack);

endmodule

// File: tb/afp_filter_tb.sv
module afp_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_vld = 1'b0;
    logic [1:0] addr_port = '0;
    logic [7:0] addr_byte = '0;
    logic       cfg_wr_en = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       dec_vld, dec_ack, dec_go, dec_cfg, dec_bank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    afp_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .addr_vld(addr_vld), .addr_port(addr_port), .addr_byte(addr_byte),
        .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .dec_vld(dec_vld), .dec_ack(dec_ack), .dec_go(dec_go),
        .dec_cfg(dec_cfg), .dec_bank(dec_bank)
    );

    // {port, byte, ack, go, cfg, bank} under reset configuration
    localparam logic [13:0] VEC [14] = '{
        {2'd0, 8'hA0, 4'b1100},   // R4 R11 write match
        {2'd0, 8'hA1, 4'b1100},   // R4 R11 read match
        {2'd0, 8'hA2, 4'b0000},   // R4 field mismatch
        {2'd1, 8'hA1, 4'b1100},   // R4 port 1 match
        {2'd1, 8'hAE, 4'b0000},   // R4 port 1 mismatch
        {2'd2, 8'hA2, 4'b1101},   // R5 bank 1
        {2'd2, 8'hA1, 4'b1100},   // R5 bank 0 read
        {2'd2, 8'hA8, 4'b0000},   // R5 field mismatch
        {2'd2, 8'hB8, 4'b1110},   // R7 cfg write
        {2'd2, 8'hB9, 4'b1110},   // R7 cfg read
        {2'd0, 8'hB8, 4'b0000},   // R7 not on port 0
        {2'd1, 8'h50, 4'b0000},   // R3 wrong code
        {2'd3, 8'hA0, 4'b0000},   // R13 unused port
        {2'd2, 8'hBA, 4'b0000}    // R3 R7 near miss
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic decide(logic [1:0] p, logic [7:0] b, logic [3:0] exp, string req);
        @(negedge clk);
        addr_vld = 1'b1; addr_port = p; addr_byte = b;
        @(negedge clk);
        addr_vld = 1'b0;
        check({req, " vld"}, 32'(dec_vld), 32'd1);
        check({req, " verdict"}, {28'd0, dec_ack, dec_go, dec_cfg, dec_bank}, 32'(exp));
    endtask

    task automatic cfg_write(logic [3:0] i, logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(logic [3:0] i, logic [7:0] exp, string req);
        @(negedge clk);
        cfg_idx = i;
        #1;
        check(req, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R2 idle after reset", {27'd0, dec_vld, dec_ack, dec_go, dec_cfg, dec_bank}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = 8'h00;
            if (i < 3) e = 8'h10;
            if (i >= 8 && i < 11) e = 8'h03;
            if (i == 15) e = 8'h21;
            cfg_read(4'(i), e, "R1 reset byte");
        end

        for (int v = 0; v < 14; v++) begin
            decide(VEC[v][13:12], VEC[v][11:4], VEC[v][3:0], "R3-7 vector");
        end

        // R2 one-cycle pulse
        @(negedge clk);
        check("R2 pulse ends", {28'd0, dec_vld, dec_ack, dec_go, dec_cfg}, 32'd0);

        // R4 programmed field
        cfg_write(4'd0, 8'h15);
        decide(2'd0, 8'hAA, 4'b1100, "R4 field 101 hit");
        decide(2'd0, 8'hA0, 4'b0000, "R4 field 101 miss");
        // R6 switch off
        cfg_write(4'd0, 8'h05);
        decide(2'd0, 8'hA0, 4'b1100, "R6 ignore field a");
        decide(2'd0, 8'hAF, 4'b1100, "R6 ignore field b");
        decide(2'd0, 8'hB0, 4'b0000, "R6 R3 code still needed");

        // R5 control field
        cfg_write(4'd2, 8'h12);
        decide(2'd2, 8'hAB, 4'b1101, "R5 field 10 bank1 read");
        decide(2'd2, 8'hA0, 4'b0000, "R5 field 10 miss");
        cfg_write(4'd2, 8'h10);

        // levels on port 1
        cfg_write(4'd9, 8'h00);
        decide(2'd1, 8'hA0, 4'b0000, "R8 shut write");
        decide(2'd1, 8'hA1, 4'b0000, "R8 shut read");
        cfg_write(4'd9, 8'h01);
        decide(2'd1, 8'hA0, 4'b1000, "R9 ackonly write");
        decide(2'd1, 8'hA1, 4'b1000, "R9 ackonly read");
        cfg_write(4'd9, 8'h02);
        decide(2'd1, 8'hA0, 4'b1000, "R10 rdonly write");
        decide(2'd1, 8'hA1, 4'b1100, "R10 rdonly read");
        cfg_write(4'd9, 8'h03);
        decide(2'd1, 8'hA0, 4'b1100, "R11 open write");
        decide(2'd0, 8'hA0, 4'b1100, "R8 port0 unaffected");

        // R7 config area ignores control level
        cfg_write(4'd10, 8'h00);
        decide(2'd2, 8'hB8, 4'b1110, "R7 cfg under shut");
        decide(2'd2, 8'hA0, 4'b0000, "R8 ctl memory shut");
        cfg_write(4'd10, 8'h01);
        decide(2'd2, 8'hA2, 4'b1001, "R9 R5 ctl ackonly bank");
        cfg_write(4'd10, 8'h03);

        // R12 storage rules
        cfg_write(4'd5, 8'h5A);
        cfg_read(4'd5, 8'h5A, "R12 reserved stores");
        cfg_write(4'd15, 8'hC3);
        cfg_read(4'd15, 8'h21, "R12 revision fixed");
        cfg_write(4'd14, 8'hE7);
        cfg_read(4'd14, 8'hE7, "R12 byte 14 stores");
        decide(2'd3, 8'hB8, 4'b0000, "R13 slot 3 cfg addr");

        finish_run();
    end

endmodule